// File: doc/BRIEF.md
# Multiplexed-Bus Banked Memory Slave

This block sits on the memory side of an 8-bit bus that carries both address and data on the same pins. A two-line phase code tells the block what the shared byte holds at any moment. It can be the upper CPU address byte, the lower CPU address byte, a byte being written, or a request for a byte to be read back. The block samples the bus on its clock, collects the 16-bit CPU address and turns it into a 17-bit flash address. It also decides whether this chip owns the access. It then gives the command interpreter behind it a single read or write strobe, the flash address and the written byte.

Two small bank registers shadow CPU-side registers. A general window register covers CPU addresses 4000h-BFFFh. A four-bit boot-window register covers C000h-DFFFh. The upper two bits of the window register must match a pair of strap inputs before the chip claims a window access, so up to four devices can share one bus, each starting at a different bank. When an access is claimed in the read phase, the block drives the byte fetched from the array. The array is a synchronous memory outside the block and is fed by the flash address.

Top module: `muxbus_bank_slave`

## Requirements
- R1: The phase code `busCode` is decoded as follows: 2'b11 means the byte on `adIn` is CPU address bits [15:8], 2'b10 means bits [7:0], 2'b00 means write data, and 2'b01 means a read. An access presents the upper byte, then the lower byte, then one data phase.
- R2: For CPU addresses 4000h-BFFFh, `flashAddr` equals the window register bits [1:0] followed by CPU address bits [14:0].
- R3: For CPU addresses C000h-DFFFh, `flashAddr` equals the four-bit boot-window register followed by CPU address bits [12:0], and the chip always claims the access.
- R4: An access in 4000h-BFFFh is claimed only when window register bits [7:6] equal `strapBank[1:0]`. Otherwise it gives no strobe and no bus drive.
- R5: A write phase to CPU address 0000h loads the window register with the data byte. A write phase to 000Dh loads the boot-window register with data bits [3:0]. Neither write gives a strobe.
- R6: `adOe` is high only in the cycles after the block has sampled the read code for a claimed access. During those cycles `adOut` carries `rdDataIn` as fetched for `flashAddr`.
- R7: Reset (`rstN` low) clears both bank registers to zero and holds `adOe`, `wrStrobe` and `rdStrobe` low.
- R8: A claimed write phase gives exactly one `wrStrobe` pulse, however many cycles the phase lasts. `wrData` then holds the byte sampled when the phase began.
- R9: A claimed read phase gives exactly one `rdStrobe` pulse, however many cycles the phase lasts.
- R10: Accesses to CPU addresses 0000h-3FFFh and E000h-FFFFh are never claimed: no strobe and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busCode | input | 2 | Phase code: [1] address/data, [0] read/write |
| adIn | input | 8 | Byte on the shared bus |
| strapBank | input | 2 | Device position straps compared with window bits [7:6] |
| rdDataIn | input | 8 | Byte from the array at `flashAddr` |
| adOut | output | 8 | Byte driven onto the shared bus |
| adOe | output | 1 | Bus driver enable |
| chipSel | output | 1 | The current address is claimed by this chip |
| flashAddr | output | 17 | Translated flash address |
| wrData | output | 8 | Byte captured in the last write phase |
| wrStrobe | output | 1 | One-cycle write request to the command interpreter |
| rdStrobe | output | 1 | One-cycle read request to the command interpreter |

## Verification
The address and the translated `flashAddr` become valid one clock edge after the lower address byte is sampled. A register shadow write takes effect one edge after the edge that first samples the write code. The strobes, `adOe` and `adOut` all appear one edge after the first sample of a data-phase code. The bench holds every phase for at least two cycles and changes inputs on the falling edge. A monitor compares each strobe against the queued expectation on the falling edge that follows its rise. After every access the bench checks that nothing is left in the queue and that the driver is released once the code returns to an address phase.

// File: rtl/mbi_pkg.sv
package mbi_pkg;

  typedef enum logic [1:0] {
    PH_WDATA   = 2'b00,
    PH_RDATA   = 2'b01,
    PH_ADDR_LO = 2'b10,
    PH_ADDR_HI = 2'b11
  } phase_e;

  typedef struct packed {
    logic capHi;
    logic capLo;
    logic wrEntry;
    logic rdEntry;
    logic rdActive;
  } busCtl_t;

endpackage

// File: rtl/mbi_ctrl.sv
module mbi_ctrl
  import mbi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busCode,
  output busCtl_t    ctl
);

  phase_e curPhase;
  phase_e prevPhase;

  assign curPhase = phase_e'(busCode);

  // Remember the previous phase so that a data phase is acted on once, at entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPhase <= PH_ADDR_HI;
    else       prevPhase <= curPhase;
  end

  always_comb begin
    ctl          = '0;
    ctl.capHi    = (curPhase == PH_ADDR_HI);
    ctl.capLo    = (curPhase == PH_ADDR_LO);
    ctl.rdActive = (curPhase == PH_RDATA);
    ctl.wrEntry  = (curPhase == PH_WDATA) && (prevPhase != PH_WDATA);
    ctl.rdEntry  = (curPhase == PH_RDATA) && (prevPhase != PH_RDATA);
  end

  // R1: the decoded phases never overlap
  a_r1_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.capHi, ctl.capLo, ctl.rdActive, ctl.wrEntry}));

endmodule

// File: rtl/mbi_datapath.sv
module mbi_datapath
  import mbi_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int BANK_KEEP_W   = 2,
  parameter int BIOS_W        = 4,
  parameter int STRAP_W       = 2,
  parameter logic [15:0] BANK_REG_ADDR = 16'h0000,
  parameter logic [15:0] BIOS_REG_ADDR = 16'h000D,
  localparam int CPU_W        = 2 * BUS_W,
  localparam int WIN_OFS_W    = CPU_W - 1,
  localparam int BIOS_OFS_W   = CPU_W - 3,
  localparam int FLASH_W      = BANK_KEEP_W + WIN_OFS_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  busCtl_t            ctl,
  input  logic [BUS_W-1:0]   adIn,
  input  logic [STRAP_W-1:0] strapBank,
  input  logic [BUS_W-1:0]   rdDataIn,
  output logic [BUS_W-1:0]   adOut,
  output logic               adOe,
  output logic               chipSel,
  output logic [FLASH_W-1:0] flashAddr,
  output logic [BUS_W-1:0]   wrData,
  output logic               wrStrobe,
  output logic               rdStrobe
);

  logic [BUS_W-1:0]  addrHi;
  logic [BUS_W-1:0]  addrLo;
  logic [CPU_W-1:0]  cpuAddr;
  logic [BUS_W-1:0]  bankSw;
  logic [BIOS_W-1:0] biosBank;
  logic              inBankWin;
  logic              inBiosWin;
  logic              strapMatch;

  assign cpuAddr = {addrHi, addrLo};

  // Address byte capture, last sample in each address phase wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi <= '0;
      addrLo <= '0;
    end else begin
      if (ctl.capHi) addrHi <= adIn;
      if (ctl.capLo) addrLo <= adIn;
    end
  end

  // Shadowed bank registers loaded on write-phase entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSw   <= '0;
      biosBank <= '0;
    end else if (ctl.wrEntry) begin
      if (cpuAddr == BANK_REG_ADDR) bankSw   <= adIn;
      if (cpuAddr == BIOS_REG_ADDR) biosBank <= adIn[BIOS_W-1:0];
    end
  end

  // Window decode: 4000h-BFFFh has top bits 01 or 10, C000h-DFFFh has top bits 110
  assign inBankWin  = (cpuAddr[CPU_W-1] ^ cpuAddr[CPU_W-2]);
  assign inBiosWin  = (cpuAddr[CPU_W-1 -: 3] == 3'b110);
  assign strapMatch = (bankSw[BUS_W-1 -: STRAP_W] == strapBank);
  assign chipSel    = (inBankWin && strapMatch) || inBiosWin;

  always_comb begin
    if (inBiosWin)
      flashAddr = FLASH_W'({biosBank, cpuAddr[BIOS_OFS_W-1:0]});
    else
      flashAddr = {bankSw[BANK_KEEP_W-1:0], cpuAddr[WIN_OFS_W-1:0]};
  end

  // Strobes, write data and bus drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
      adOe     <= 1'b0;
      adOut    <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= ctl.wrEntry && chipSel;
      rdStrobe <= ctl.rdEntry && chipSel;
      adOe     <= ctl.rdActive && chipSel;
      adOut    <= (ctl.rdActive && chipSel) ? rdDataIn : '0;
      if (ctl.wrEntry) wrData <= adIn;
    end
  end

  // R6: the driver only turns on after a claimed read sample
  a_r6_oe_in_read: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> ($past(ctl.rdActive) && $past(chipSel)));

  // R8: one write strobe per write phase
  a_r8_wr_once: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R9: one read strobe per read phase
  a_r9_rd_once: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe);

  // R4: a write strobe is only issued for a claimed address
  a_r4_wr_selected: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(chipSel));

  // R5: the window register only changes after a write-phase entry
  a_r5_bank_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bankSw) |-> $past(ctl.wrEntry));

  // R7: quiet bus while in reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_r7_reset_quiet: assert (!adOe && !wrStrobe && !rdStrobe);
    end
  end

endmodule

// File: rtl/muxbus_bank_slave.sv
module muxbus_bank_slave
  import mbi_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int BANK_KEEP_W = 2,
  parameter int BIOS_W      = 4,
  parameter int STRAP_W     = 2,
  localparam int FLASH_W    = BANK_KEEP_W + 2 * BUS_W - 1
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         busCode,
  input  logic [BUS_W-1:0]   adIn,
  input  logic [STRAP_W-1:0] strapBank,
  input  logic [BUS_W-1:0]   rdDataIn,
  output logic [BUS_W-1:0]   adOut,
  output logic               adOe,
  output logic               chipSel,
  output logic [FLASH_W-1:0] flashAddr,
  output logic [BUS_W-1:0]   wrData,
  output logic               wrStrobe,
  output logic               rdStrobe
);

  busCtl_t ctl;

  mbi_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busCode (busCode),
    .ctl     (ctl)
  );

  mbi_datapath #(
    .BUS_W       (BUS_W),
    .BANK_KEEP_W (BANK_KEEP_W),
    .BIOS_W      (BIOS_W),
    .STRAP_W     (STRAP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .adIn      (adIn),
    .strapBank (strapBank),
    .rdDataIn  (rdDataIn),
    .adOut     (adOut),
    .adOe      (adOe),
    .chipSel   (chipSel),
    .flashAddr (flashAddr),
    .wrData    (wrData),
    .wrStrobe  (wrStrobe),
    .rdStrobe  (rdStrobe)
  );

endmodule

// File: tb/sim_muxbus_bank_slave.sv
module sim_muxbus_bank_slave;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busCode = 2'b11;
  logic [7:0]  adIn = '0;
  logic [1:0]  strapBank = 2'b00;
  logic [7:0]  rdDataIn;
  logic [7:0]  adOut;
  logic        adOe;
  logic        chipSel;
  logic [16:0] flashAddr;
  logic [7:0]  wrData;
  logic        wrStrobe;
  logic        rdStrobe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_bank_slave u0 (
    .clk(clk), .rstN(rstN), .busCode(busCode), .adIn(adIn),
    .strapBank(strapBank), .rdDataIn(rdDataIn), .adOut(adOut), .adOe(adOe),
    .chipSel(chipSel), .flashAddr(flashAddr), .wrData(wrData),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe)
  );

  // Array model: contents are a fixed function of the address
  function automatic logic [7:0] memByte(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]} ^ 8'h5C;
  endfunction
  assign rdDataIn = memByte(flashAddr);

  // Bench-side model of the shadow registers
  logic [7:0] mBank = '0;
  logic [3:0] mBios = '0;

  function automatic bit expSel(input logic [15:0] a);
    return ((a >= 16'h4000) && (a <= 16'hBFFF) && (mBank[7:6] == strapBank)) ||
           ((a >= 16'hC000) && (a <= 16'hDFFF));
  endfunction

  function automatic logic [16:0] expAddr(input logic [15:0] a);
    if ((a >= 16'hC000) && (a <= 16'hDFFF)) return {mBios, a[12:0]};
    return {mBank[1:0], a[14:0]};
  endfunction

  typedef struct {
    bit          isRd;
    logic [16:0] addr;
    logic [7:0]  data;
    string       req;
  } exp_t;

  exp_t expQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every strobe pops one expectation
  always @(negedge clk) begin
    if (rstN && !done && (wrStrobe || rdStrobe)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R4/R10", "unexpected strobe at flashAddr", {15'b0, flashAddr}, 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(rdStrobe == e.isRd && wrStrobe == !e.isRd, e.req, "strobe kind",
            {30'b0, rdStrobe, wrStrobe}, e.isRd ? 32'h2 : 32'h1);
        chk(flashAddr == e.addr, e.req, "flashAddr", {15'b0, flashAddr}, {15'b0, e.addr});
        if (e.isRd) begin
          chk(adOe == 1'b1, e.req, "adOe in read", {31'b0, adOe}, 32'h1);
          chk(adOut == e.data, e.req, "adOut", {24'b0, adOut}, {24'b0, e.data});
        end else begin
          chk(wrData == e.data, e.req, "wrData", {24'b0, wrData}, {24'b0, e.data});
        end
      end
    end
  end

  // Driver: one full access, phases held for two cycles, data phase for nData cycles
  task automatic busAccess(input logic [15:0] a, input bit isRd, input logic [7:0] d,
                           input int nData, input string req);
    bit sel;
    @(negedge clk); busCode = 2'b11; adIn = a[15:8];
    @(negedge clk);
    @(negedge clk); busCode = 2'b10; adIn = a[7:0];
    @(negedge clk);
    sel = expSel(a);
    if (sel) begin
      exp_t e;
      e.isRd = isRd;
      e.addr = expAddr(a);
      e.data = isRd ? memByte(expAddr(a)) : d;
      e.req  = req;
      expQ.push_back(e);
    end
    busCode = isRd ? 2'b01 : 2'b00;
    adIn    = isRd ? 8'hA5 : d;
    for (int i = 0; i < nData; i++) begin
      @(negedge clk);
      if (isRd && i > 0)
        chk(adOe == sel, req, "adOe held through read phase", {31'b0, adOe}, {31'b0, sel});
    end
    busCode = 2'b11; adIn = '0;
    @(negedge clk);
    chk(expQ.size() == 0, req, "missing strobe", expQ.size(), 0);
    expQ.delete();
    chk(adOe == 1'b0, req, "adOe released after access", {31'b0, adOe}, 32'h0);
    if (!isRd && a == 16'h0000) mBank = d;
    if (!isRd && a == 16'h000D) mBios = d[3:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: quiet while in reset
    chk(adOe == 1'b0, "R7", "adOe in reset", {31'b0, adOe}, 32'h0);
    chk(!wrStrobe && !rdStrobe, "R7", "strobes in reset", {30'b0, wrStrobe, rdStrobe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(chipSel == 1'b0, "R10", "chipSel at address 0000h", {31'b0, chipSel}, 32'h0);

    // R7, R2: cleared window register maps 4000h to flash 04000h
    busAccess(16'h4000, 1'b1, 8'h00, 2, "R7");
    // R5: load window register, no strobe
    busAccess(16'h0000, 1'b0, 8'h03, 2, "R5");
    // R2, R1: read and write through the window
    busAccess(16'h8123, 1'b1, 8'h00, 2, "R2");
    busAccess(16'h9ABC, 1'b0, 8'h5A, 2, "R2");
    busAccess(16'hBFFF, 1'b1, 8'h00, 2, "R1");
    // R5, R3: boot-window register and its window
    busAccess(16'h000D, 1'b0, 8'hF7, 2, "R5");
    busAccess(16'hC456, 1'b1, 8'h00, 2, "R3");
    busAccess(16'hDFFF, 1'b0, 8'h11, 2, "R3");
    // R8: long write phase gives one strobe
    busAccess(16'h6001, 1'b0, 8'hC3, 5, "R8");
    // R9: long read phase gives one strobe
    busAccess(16'h7002, 1'b1, 8'h00, 4, "R9");

    // R4: strap mismatch, window access ignored, boot window still claimed
    @(negedge clk); strapBank = 2'b01;
    busAccess(16'h4000, 1'b1, 8'h00, 2, "R4");
    busAccess(16'hA000, 1'b0, 8'h77, 2, "R4");
    busAccess(16'hC000, 1'b1, 8'h00, 2, "R4");
    busAccess(16'h0000, 1'b0, 8'h42, 2, "R5");
    busAccess(16'h5000, 1'b1, 8'h00, 2, "R4");
    busAccess(16'h5000, 1'b0, 8'h99, 3, "R4");

    // R10: outside both windows
    busAccess(16'h2000, 1'b1, 8'h00, 2, "R10");
    busAccess(16'h3FFF, 1'b0, 8'h12, 2, "R10");
    busAccess(16'hE000, 1'b1, 8'h00, 2, "R10");
    busAccess(16'hFFFF, 1'b0, 8'h34, 2, "R10");

    // R6: read right after a write keeps the drive tied to the read phase
    busAccess(16'h4ABC, 1'b1, 8'h00, 3, "R6");

    // R7: reset clears the registers again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(adOe == 1'b0, "R7", "adOe in second reset", {31'b0, adOe}, 32'h0);
    rstN = 1'b1; mBank = '0; mBios = '0; strapBank = 2'b00;
    busAccess(16'hC001, 1'b1, 8'h00, 2, "R7");
    busAccess(16'h4002, 1'b0, 8'h66, 2, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule